// File: doc/BRIEF.md
# 16:1 Serializer with Loopback Select

This block turns 16-bit parallel words into a bit-serial stream at sixteen times the word rate. A single divide-by-16 timing generator runs on the serial clock. It produces three things: a one-cycle word strobe that loads the shift register and pops the upstream decoupling FIFO, a parallel-rate clock for the upstream logic, and a divided feedback clock for the phase detector of the clock synthesizer. Each word is sent most significant bit first.

Two output multiplexers select the loopback modes. Line loopback replaces the serializer's serial data and clock on the transmit pins with externally supplied serial data and clock. Diagnostic loopback routes the serializer's data and clock to the receive side, where they take the place of the normal receive stream. Both enables are active-low. Each is registered in the serial clock domain before it switches its multiplexer. Both modes may be on together.

Top module: `ser16_tx`

## Requirements
- R1: While rst_ni is low, par_clk_o, fb_clk_o and word_ld_o are 0, the internal serial bit is 0, and both loopback modes read as inactive.
- R2: Rising serial-clock edges are counted from reset release. word_ld_o is high for exactly one serial cycle in every 16, following edges 15, 31, 47 and so on. The word on par_data_i is captured at the next edge.
- R3: After the edge that captures a word, the serial bit is bit 15 of that word. Each later edge moves it one position lower, down to bit 0. Before the first capture the serial bit is 0.
- R4: par_clk_o is the serial clock divided by 16. It is low after edges whose count modulo 16 is 0 to 7 and high after edges 8 to 15, so it falls at each word-capture edge.
- R5: fb_clk_o is the serial clock divided by FB_DIV. With the default FB_DIV equal to 16 it is identical to par_clk_o.
- R6: line_lb_ni is active-low and sampled on each serial edge. After an edge that sampled it low, tx_data_o equals lline_data_i and tx_clk_o equals lline_clk_i. Otherwise tx_data_o is the serial bit and tx_clk_o is clk_i.
- R7: diag_lb_ni is active-low and sampled on each serial edge. After an edge that sampled it low, rx_data_o is the serial bit and rx_clk_o is clk_i. Otherwise they pass rx_data_i and rx_clk_i.
- R8: Both loopbacks may be active at the same time, each following its own rule. Neither enable disturbs the word strobe, the clocks or the serial bit sequence.
- R9: A reset applied mid-stream clears the divider phase. After release, counting of R2 to R4 restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_data_i | input | 16 | Parallel word from the decoupling FIFO |
| lline_data_i | input | 1 | External serial data for line loopback |
| lline_clk_i | input | 1 | External serial clock for line loopback |
| rx_data_i | input | 1 | Normal receive serial data |
| rx_clk_i | input | 1 | Normal receive serial clock |
| line_lb_ni | input | 1 | Line loopback enable, active low |
| diag_lb_ni | input | 1 | Diagnostic loopback enable, active low |
| word_ld_o | output | 1 | Word strobe, one serial cycle per word |
| par_clk_o | output | 1 | Parallel-rate clock |
| fb_clk_o | output | 1 | Phase-detector feedback clock |
| tx_data_o | output | 1 | Transmit serial data |
| tx_clk_o | output | 1 | Transmit serial clock |
| rx_data_o | output | 1 | Serial data to the receive side |
| rx_clk_o | output | 1 | Serial clock to the receive side |

## Verification
The serializer is first fed all-ones, all-zeros, 16'h8001 and 16'hAAAA. These words show a reversed bit order, a lost end bit or a shift off by one position. Random words follow. The loopback enables are then toggled at random, including long spans with both active, while the loopback and receive inputs carry random values. This separates mux swaps, a missing enable register and any leakage of one mode into the other. A mid-stream reset confirms that the clock outputs are held low and that the divider phase restarts.

// File: rtl/ser16_pkg.sv
package ser16_pkg;
  typedef struct packed {
    logic line;
    logic diag;
  } lb_mode_t;
endpackage

// File: rtl/ser16_timing.sv
module ser16_timing #(
  parameter int WORD_W = 16,
  parameter int FB_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic word_ld_o,
  output logic par_clk_o,
  output logic fb_clk_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pclk_q;

  assign word_ld_o = (cnt_q == LAST);
  assign cnt_nxt   = word_ld_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      pclk_q <= (cnt_nxt >= HALF);
    end
  end

  assign par_clk_o = pclk_q;

  generate
    if (FB_DIV == WORD_W) begin : g_fb_shared
      assign fb_clk_o = pclk_q;
    end else begin : g_fb_own
      localparam int FB_W = $clog2(FB_DIV);
      localparam logic [FB_W-1:0] FB_LAST = FB_W'(FB_DIV - 1);
      localparam logic [FB_W-1:0] FB_HALF = FB_W'(FB_DIV / 2);
      logic [FB_W-1:0] fb_q, fb_nxt;
      logic            fbclk_q;
      assign fb_nxt = (fb_q == FB_LAST) ? '0 : fb_q + 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          fb_q    <= '0;
          fbclk_q <= 1'b0;
        end else begin
          fb_q    <= fb_nxt;
          fbclk_q <= (fb_nxt >= FB_HALF);
        end
      end
      assign fb_clk_o = fbclk_q;
    end
  endgenerate
endmodule

// File: rtl/ser16_shift.sv
module ser16_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= word_i;
    else             sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[WORD_W-1];
endmodule

// File: rtl/ser16_lbsel.sv
module ser16_lbsel
  import ser16_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_lb_ni,
  input  logic diag_lb_ni,
  input  logic ser_bit_i,
  input  logic lline_data_i,
  input  logic lline_clk_i,
  input  logic rx_data_i,
  input  logic rx_clk_i,
  output logic tx_data_o,
  output logic tx_clk_o,
  output logic rx_data_o,
  output logic rx_clk_o
);
  lb_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= '{line: ~line_lb_ni, diag: ~diag_lb_ni};
  end

  assign tx_data_o = mode_q.line ? lline_data_i : ser_bit_i;
  assign tx_clk_o  = mode_q.line ? lline_clk_i  : clk_i;
  assign rx_data_o = mode_q.diag ? ser_bit_i    : rx_data_i;
  assign rx_clk_o  = mode_q.diag ? clk_i        : rx_clk_i;
endmodule

// File: rtl/ser16_tx.sv
module ser16_tx #(
  parameter int WORD_W = 16,
  parameter int FB_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] par_data_i,
  input  logic              lline_data_i,
  input  logic              lline_clk_i,
  input  logic              rx_data_i,
  input  logic              rx_clk_i,
  input  logic              line_lb_ni,
  input  logic              diag_lb_ni,
  output logic              word_ld_o,
  output logic              par_clk_o,
  output logic              fb_clk_o,
  output logic              tx_data_o,
  output logic              tx_clk_o,
  output logic              rx_data_o,
  output logic              rx_clk_o
);
  logic ser_bit;

  ser16_timing #(.WORD_W(WORD_W), .FB_DIV(FB_DIV)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_ld_o(word_ld_o),
    .par_clk_o(par_clk_o),
    .fb_clk_o (fb_clk_o)
  );

  ser16_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(word_ld_o),
    .word_i(par_data_i),
    .bit_o (ser_bit)
  );

  ser16_lbsel u_lbsel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_lb_ni  (line_lb_ni),
    .diag_lb_ni  (diag_lb_ni),
    .ser_bit_i   (ser_bit),
    .lline_data_i(lline_data_i),
    .lline_clk_i (lline_clk_i),
    .rx_data_i   (rx_data_i),
    .rx_clk_i    (rx_clk_i),
    .tx_data_o   (tx_data_o),
    .tx_clk_o    (tx_clk_o),
    .rx_data_o   (rx_data_o),
    .rx_clk_o    (rx_clk_o)
  );
endmodule

// File: rtl/ser16_tx_chk.sv
module ser16_tx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] par_data_i,
  input logic              word_ld_i,
  input logic              par_clk_i,
  input logic              ser_bit_i,
  input logic              line_lb_ni,
  input logic              diag_lb_ni,
  input logic              lline_data_i,
  input logic              tx_data_i,
  input logic              rx_data_i
);
  // R2: strobe lasts one serial cycle
  assert_ld_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ld_i |=> !word_ld_i);

  // R3: captured word MSB appears first
  assert_msb_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ld_i |=> (ser_bit_i == $past(par_data_i[WORD_W-1])));

  // R4: parallel clock falls at the capture edge
  assert_pclk_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ld_i |=> $fell(par_clk_i));

  // R6: line loopback selects external data one edge after enable
  assert_line_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_lb_ni |=> (tx_data_i == lline_data_i));

  // R7: diagnostic loopback routes the serial bit to the receive side
  assert_diag_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !diag_lb_ni |=> (rx_data_i == ser_bit_i));
endmodule

bind ser16_tx ser16_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .par_data_i  (par_data_i),
  .word_ld_i   (word_ld_o),
  .par_clk_i   (par_clk_o),
  .ser_bit_i   (ser_bit),
  .line_lb_ni  (line_lb_ni),
  .diag_lb_ni  (diag_lb_ni),
  .lline_data_i(lline_data_i),
  .tx_data_i   (tx_data_o),
  .rx_data_i   (rx_data_o)
);

// File: tb/sim_ser16_tx.sv
`timescale 1ns/1ps
module sim_ser16_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] par_data = 16'hFFFF;
  logic        lline_data = 1'b0, lline_clk = 1'b1;
  logic        rx_data = 1'b0, rx_clk = 1'b1;
  logic        line_lb_n = 1'b1, diag_lb_n = 1'b1;
  logic        word_ld, par_clk, fb_clk, tx_data, tx_clk, rx_data_o, rx_clk_o;

  int unsigned n_run = 0, n_fail = 0;
  int unsigned e = 0;
  logic        line_r = 1'b0, diag_r = 1'b0;
  logic [15:0] cur_w = 16'h0000, pend_w = 16'hFFFF;
  int unsigned n_load = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ser16_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .par_data_i(par_data),
    .lline_data_i(lline_data), .lline_clk_i(lline_clk),
    .rx_data_i(rx_data), .rx_clk_i(rx_clk),
    .line_lb_ni(line_lb_n), .diag_lb_ni(diag_lb_n),
    .word_ld_o(word_ld), .par_clk_o(par_clk), .fb_clk_o(fb_clk),
    .tx_data_o(tx_data), .tx_clk_o(tx_clk),
    .rx_data_o(rx_data_o), .rx_clk_o(rx_clk_o)
  );

  // edge count since reset release and registered enable view (R2, R6, R7)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e <= 0; line_r <= 1'b0; diag_r <= 1'b0;
    end else begin
      e <= e + 1; line_r <= ~line_lb_n; diag_r <= ~diag_lb_n;
    end
  end

  function automatic logic exp_ser(int unsigned ec, logic [15:0] w);
    if (ec < 16) return 1'b0;
    return w[15 - (ec % 16)];
  endfunction

  function automatic logic exp_pclk(int unsigned ec);
    return (ec % 16) >= 8;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, e);
    end
  endtask

  task automatic check_cycle();
    logic s;
    if (e % 16 == 0 && e > 0) cur_w = pend_w;
    s = exp_ser(e, cur_w);
    chk(word_ld == ((e % 16) == 15), "R2 word_ld", 16'(word_ld), 16'((e % 16) == 15));
    chk(par_clk == exp_pclk(e), "R4 par_clk", 16'(par_clk), 16'(exp_pclk(e)));
    chk(fb_clk == exp_pclk(e), "R5 fb_clk", 16'(fb_clk), 16'(exp_pclk(e)));
    if (line_r) begin
      chk(tx_data == lline_data, "R6 tx_data line", 16'(tx_data), 16'(lline_data));
      chk(tx_clk == lline_clk, "R6 tx_clk line", 16'(tx_clk), 16'(lline_clk));
    end else begin
      chk(tx_data == s, "R3 tx_data serial", 16'(tx_data), 16'(s));
      chk(tx_clk == 1'b0, "R6 tx_clk serial", 16'(tx_clk), 16'h0);
    end
    if (diag_r) begin
      chk(rx_data_o == s, (line_r ? "R8 rx_data both" : "R7 rx_data diag"), 16'(rx_data_o), 16'(s));
      chk(rx_clk_o == 1'b0, "R7 rx_clk diag", 16'(rx_clk_o), 16'h0);
    end else begin
      chk(rx_data_o == rx_data, "R7 rx_data pass", 16'(rx_data_o), 16'(rx_data));
      chk(rx_clk_o == rx_clk, "R7 rx_clk pass", 16'(rx_clk_o), 16'(rx_clk));
    end
  endtask

  task automatic drive_cycle(input int mode);
    if (e % 16 == 0 && e > 0) begin
      n_load++;
      case (n_load)
        1: pend_w = 16'h0000;
        2: pend_w = 16'h8001;
        3: pend_w = 16'hAAAA;
        default: pend_w = 16'($urandom);
      endcase
      par_data = pend_w;
    end
    lline_data = 1'($urandom); lline_clk = 1'($urandom);
    rx_data = 1'($urandom);    rx_clk = 1'($urandom);
    if (mode == 1) begin
      if ($urandom % 24 == 0) line_lb_n = ~line_lb_n;
      if ($urandom % 24 == 0) diag_lb_n = ~diag_lb_n;
    end else if (mode == 2) begin
      line_lb_n = 1'b0; diag_lb_n = 1'b0;
    end else begin
      line_lb_n = 1'b1; diag_lb_n = 1'b1;
    end
  endtask

  task automatic run(input int cycles, input int mode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_cycle();
      drive_cycle(mode);
    end
  endtask

  task automatic reset_phase(input int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(par_clk == 1'b0, "R1 par_clk in reset", 16'(par_clk), 16'h0);
      chk(fb_clk == 1'b0, "R1 fb_clk in reset", 16'(fb_clk), 16'h0);
      chk(word_ld == 1'b0, "R1 word_ld in reset", 16'(word_ld), 16'h0);
      chk(tx_data == 1'b0, "R1 serial bit in reset", 16'(tx_data), 16'h0);
      chk(rx_data_o == rx_data, "R1 diag inactive in reset", 16'(rx_data_o), 16'(rx_data));
      line_lb_n = 1'b0; diag_lb_n = 1'b0;
      rx_data = 1'($urandom);
    end
    line_lb_n = 1'b1; diag_lb_n = 1'b1;
    cur_w = 16'h0000; pend_w = 16'hFFFF; par_data = pend_w; n_load = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    reset_phase(6);
    run(400, 0);
    run(600, 1);
    run(64, 2);
    run(200, 1);
    // R9: mid-stream reset restarts the divider phase
    @(negedge clk);
    reset_phase(5);
    run(200, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule